// File: doc/BRIEF.md
# Conversion-Start Slot Arbiter

The arbiter decides which of sixteen conversion-start slots gets the single shared converter next. Slots numbered below a programmable count (`hi_count`) form the high-priority group. Each of these slots has its own trigger input and a pending flag. The slots from `hi_count` up to 15 form the burst group. Their own trigger inputs are not used. Instead, one burst trigger releases `burst_size` burst slots, which are issued one after another. A burst pointer remembers where the last group stopped, so the next trigger carries on from there. The converter is outside this block. It answers each start with a one-cycle `conv_done` pulse.

Control is a two-state machine. In **IDLE** the converter is free. **IDLE→CONV** is taken on any cycle where a high-priority slot is pending or burst slots are still owed. The block issues one start strobe and the chosen slot number on that edge. In **CONV** the converter is working. **CONV→IDLE** is taken on the edge that samples `conv_done`. **CONV→CONV** (hold) covers every other cycle, so a conversion is never cut short. Triggers that arrive during CONV are only recorded. The earliest next start is one cycle after the return to IDLE. The outcome is fixed at each slot boundary: a pending high-priority slot always beats the burst sequence. A high-priority trigger can therefore push itself between two burst slots of the same group.

Top module: `soc_arbiter`

## Requirements
- R1: After reset `start`, `busy` and `overflow` are 0 and `issue_slot` is 0. No slot is pending and no burst slot is owed.
- R2: A trigger on slot i with i < `hi_count` makes slot i pending from the next cycle. In IDLE, the lowest-numbered pending high-priority slot is issued. It is issued ahead of any owed burst slot.
- R3: While `busy` is 1, no start is issued. `busy` stays 1 until the cycle in which `conv_done` is 1 and drops on the next edge. A new start can come no earlier than the cycle after that.
- R4: `start` is high for exactly one cycle. `busy` rises in that same cycle. `issue_slot` holds the granted slot from that cycle until the next start.
- R5: If no burst slot is owed and `hi_count` < 16, a `burst_trig` pulse makes `burst_size` burst slots owed. They are issued one per free converter slot, at consecutive slot numbers. The next group starts right after the last slot of the previous group.
- R6: The burst slot issued is the pointer, raised to `hi_count` if the pointer is below it. After slot 15 the pointer wraps to `hi_count`. A `burst_size` of 0 acts as 1.
- R7: A trigger on a high-priority slot that is already pending, and not being issued that cycle, is merged into the pending request. A `burst_trig` while burst slots are still owed is also merged, and adds no slots. Either kind of merge sets `overflow`, which stays 1 until reset.
- R8: These inputs have no effect: triggers on slots at or above `hi_count`, `burst_trig` when `hi_count` ≥ 16, and `conv_done` while not busy.
- R9: A high-priority slot that becomes pending during a burst group is issued at the next free converter slot. The rest of the group then continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_trig | input | 16 | Per-slot trigger pulses |
| burst_trig | input | 1 | Burst group trigger pulse |
| hi_count | input | 5 | Number of high-priority slots (0..16) |
| burst_size | input | 4 | Slots issued per burst trigger (0 treated as 1) |
| conv_done | input | 1 | Converter completion pulse |
| start | output | 1 | One-cycle conversion start strobe |
| issue_slot | output | 4 | Slot number of the latest start |
| busy | output | 1 | Converter occupied |
| overflow | output | 1 | Sticky flag for merged triggers |

## Verification
Suppose the burst pointer or the owed count goes wrong. The slot number of the very next burst start would then differ from the expected sequence, or the start would come one group early or late. A lost or stuck pending flag shows up as a start missing or added at the first free converter slot. A wrong state in the machine shows up as `busy` disagreeing with the converter handshake on the cycle after `conv_done`. Every port is compared with an independent model on every cycle, so any such fault shows up within one conversion time.

// File: rtl/soc_arb_pkg.sv
package soc_arb_pkg;
    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } arb_state_e;
endpackage

// File: rtl/soc_pend_bank.sv
module soc_pend_bank #(
    parameter int N      = 16,
    parameter int SLOT_W = $clog2(N),
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      trig,
    input  logic [CNT_W-1:0]  hi_count,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_idx,
    output logic              hi_any,
    output logic [SLOT_W-1:0] hi_idx,
    output logic              merge_hit
);
    logic [N-1:0] pend_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [CNT_W-1:0]  IDX_C = CNT_W'(i);
        localparam logic [SLOT_W-1:0] IDX_S = SLOT_W'(i);
        logic is_hi, set_i, clr_i;
        assign is_hi  = IDX_C < hi_count;
        assign set_i  = trig[i] & is_hi;
        assign clr_i  = clr_en & (clr_idx == IDX_S);
        assign hit[i] = set_i & pend_q[i] & ~clr_i;
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= (pend_q[i] & ~clr_i) | set_i;
        end
    end

    // lowest pending index wins
    always_comb begin
        hi_any = 1'b0;
        hi_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend_q[k]) begin
                hi_any = 1'b1;
                hi_idx = SLOT_W'(k);
            end
        end
    end

    assign merge_hit = |hit;
endmodule

// File: rtl/soc_burst_seq.sv
module soc_burst_seq #(
    parameter int N      = 16,
    parameter int SLOT_W = $clog2(N),
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_trig,
    input  logic [CNT_W-1:0]  hi_count,
    input  logic [SLOT_W-1:0] burst_size,
    input  logic              take,
    output logic              owed,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              merge_hit
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N - 1);

    logic [SLOT_W-1:0] ptr_q;
    logic [CNT_W-1:0]  rem_q;
    logic              enabled;
    logic [SLOT_W-1:0] base;
    logic [CNT_W-1:0]  size_eff;

    assign enabled   = hi_count < CNT_W'(N);
    assign base      = hi_count[SLOT_W-1:0];
    assign size_eff  = (burst_size == '0) ? CNT_W'(1) : CNT_W'(burst_size);
    assign cur_slot  = (ptr_q < base) ? base : ptr_q;
    assign owed      = enabled & (rem_q != '0);
    assign merge_hit = burst_trig & enabled & (rem_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            rem_q <= '0;
        end else begin
            if (burst_trig && enabled && rem_q == '0) begin
                rem_q <= size_eff;
            end else if (take) begin
                rem_q <= rem_q - 1'b1;
            end
            if (take) begin
                ptr_q <= (cur_slot == LAST) ? base : cur_slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/soc_arbiter.sv
module soc_arbiter
    import soc_arb_pkg::*;
#(
    parameter int N      = NUM_SLOTS,
    parameter int SW     = $clog2(N),
    parameter int CW     = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  slot_trig,
    input  logic          burst_trig,
    input  logic [CW-1:0] hi_count,
    input  logic [SW-1:0] burst_size,
    input  logic          conv_done,
    output logic          start,
    output logic [SW-1:0] issue_slot,
    output logic          busy,
    output logic          overflow
);
    arb_state_e    state_q, state_nx;
    logic          hi_any, b_owed, grant, take_hi, take_burst;
    logic [SW-1:0] hi_idx, b_slot;
    logic          hi_merge, b_merge;
    logic          start_q, ovf_q;
    logic [SW-1:0] slot_q;

    soc_pend_bank #(.N(N), .SLOT_W(SW), .CNT_W(CW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (slot_trig),
        .hi_count  (hi_count),
        .clr_en    (take_hi),
        .clr_idx   (hi_idx),
        .hi_any    (hi_any),
        .hi_idx    (hi_idx),
        .merge_hit (hi_merge)
    );

    soc_burst_seq #(.N(N), .SLOT_W(SW), .CNT_W(CW)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_trig (burst_trig),
        .hi_count   (hi_count),
        .burst_size (burst_size),
        .take       (take_burst),
        .owed       (b_owed),
        .cur_slot   (b_slot),
        .merge_hit  (b_merge)
    );

    assign grant      = (state_q == ST_IDLE) & (hi_any | b_owed);
    assign take_hi    = grant & hi_any;
    assign take_burst = grant & ~hi_any;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (hi_any || b_owed) state_nx = ST_CONV;
            ST_CONV: if (conv_done)        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            slot_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            start_q <= grant;
            if (grant) slot_q <= hi_any ? hi_idx : b_slot;
            ovf_q   <= ovf_q | hi_merge | b_merge;
        end
    end

    assign start      = start_q;
    assign issue_slot = slot_q;
    assign busy       = (state_q == ST_CONV);
    assign overflow   = ovf_q;
endmodule

// File: rtl/soc_arb_chk.sv
module soc_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic conv_done,
    input logic overflow
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> busy);
    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start);
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind soc_arbiter soc_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .conv_done (conv_done),
    .overflow  (overflow)
);

// File: tb/tb_soc_arbiter.sv
`timescale 1ns/1ps
module tb_soc_arbiter;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] slot_trig = '0;
    logic        burst_trig = 1'b0;
    logic [4:0]  hc = 5'd4;
    logic [3:0]  sz = 4'd2;
    logic        auto_done = 1'b0, stray_done = 1'b0;
    logic        conv_done;
    logic        start, busy, overflow;
    logic [3:0]  issue_slot;

    assign conv_done = auto_done | stray_done;
    always #5 clk = ~clk;

    soc_arbiter dut (
        .clk(clk), .rst_n(rst_n), .slot_trig(slot_trig), .burst_trig(burst_trig),
        .hi_count(hc), .burst_size(sz), .conv_done(conv_done),
        .start(start), .issue_slot(issue_slot), .busy(busy), .overflow(overflow)
    );

    int    errors = 0, checks = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    bit [15:0] m_pend;
    int        m_rem, m_ptr, m_slot;
    bit        m_busy, m_start, m_ovf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_rem = 0; m_ptr = 0; m_slot = 0;
            m_busy = 0; m_start = 0; m_ovf = 0;
        end else begin
            int  pick, bsz;
            bit  g, cleared_hi;
            pick = -1; cleared_hi = 0;
            for (int i = 15; i >= 0; i--) if (m_pend[i]) pick = i;
            g = !m_busy && (pick >= 0 || (m_rem > 0 && hc < 16));
            if (g) begin
                if (pick >= 0) begin
                    m_pend[pick] = 0; cleared_hi = 1; m_slot = pick;
                end else begin
                    int s;
                    s = (m_ptr < hc) ? int'(hc) : m_ptr;
                    m_slot = s;
                    m_ptr = (s == 15) ? int'(hc) : s + 1;
                    m_rem--;
                end
            end
            for (int i = 0; i < 16; i++) begin
                if (slot_trig[i] && i < hc) begin
                    if (m_pend[i] && !(cleared_hi && m_slot == i)) m_ovf = 1;
                    m_pend[i] = 1;
                end
            end
            bsz = (sz == 0) ? 1 : int'(sz);
            if (burst_trig && hc < 16) begin
                if (m_rem != 0 && !(g && pick < 0 && m_rem == 0)) m_ovf = 1;
                if (m_rem == 0 && !(g && pick < 0)) m_rem = bsz;
            end
            if (m_busy && conv_done) m_busy = 0;
            else if (g)              m_busy = 1;
            m_start = g;
        end
    end

    // converter stand-in
    int conv_cnt = 0;
    always @(negedge clk) begin
        auto_done <= 1'b0;
        if (rst_n) begin
            if (m_start) conv_cnt = LAT;
            else if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) auto_done <= 1'b1;
            end
        end else conv_cnt = 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison and protocol checks
    bit prev_busy = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(start == m_start, cur_req, "start", start, m_start);
            check(busy == m_busy, cur_req, "busy", busy, m_busy);
            check(overflow == m_ovf, cur_req, "overflow", overflow, m_ovf);
            check(int'(issue_slot) == m_slot, cur_req, "issue_slot", issue_slot, m_slot);
            if (start) begin
                check(!prev_busy, "R3", "start while converting", prev_busy, 0);
                check(busy, "R4", "busy with start", busy, 1);
            end
        end
        prev_busy = busy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_slots(input logic [15:0] m);
        @(negedge clk); slot_trig = m;
        @(negedge clk); slot_trig = '0;
    endtask
    task automatic pulse_burst();
        @(negedge clk); burst_trig = 1'b1;
        @(negedge clk); burst_trig = 1'b0;
    endtask
    task automatic do_reset(input logic [4:0] h, input logic [3:0] s);
        @(negedge clk); rst_n = 1'b0; hc = h; sz = s;
        tick(3);
        check(start == 0 && busy == 0 && overflow == 0 && issue_slot == 0,
              "R1", "reset outputs", {start, busy, overflow}, 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset(5'd4, 4'd2);
        cur_req = "R2";
        pulse_slots(16'b0110);          // slots 1 and 2 together
        tick(25);
        pulse_slots(16'b1000);
        pulse_burst();                  // high slot 3 pending beats burst
        tick(40);
        cur_req = "R9";
        pulse_burst();
        tick(2);
        pulse_slots(16'b0001);          // lands mid-group
        tick(40);
        cur_req = "R5";
        for (int k = 0; k < 4; k++) begin pulse_burst(); tick(25); end
        cur_req = "R7";
        pulse_slots(16'b0010);
        pulse_slots(16'b1000);
        pulse_slots(16'b1000);          // merged
        pulse_burst();
        pulse_burst();                  // merged
        tick(60);
        check(overflow == 1, "R7", "sticky overflow", overflow, 1);

        do_reset(5'd12, 4'd3);
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin pulse_burst(); tick(30); end
        sz = 4'd0;
        for (int k = 0; k < 3; k++) begin pulse_burst(); tick(12); end

        cur_req = "R8";
        pulse_slots(16'h2000);          // slot 13 is in burst group
        tick(5);
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        tick(3);
        check(busy == 0 && start == 0, "R8", "ignored inputs idle", busy, 0);
        do_reset(5'd16, 4'd2);
        pulse_burst();
        tick(10);
        check(busy == 0, "R8", "burst with no burst slots", busy, 0);
        pulse_slots(16'h8000);          // slot 15 high now
        tick(20);

        cur_req = "R3";
        do_reset(5'd4, 4'd4);
        pulse_burst();
        pulse_slots(16'b0101);
        tick(60);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule